// File: doc/BRIEF.md
# Masked Register Rotation Unit

This unit holds a file of six data registers: four source slots (S0 to S3) and two destination slots (D0, D1). It carries out one update command. A start pulse arrives with a five-bit immediate. The unit adds the immediate, read as a signed value, to S0. It then rotates values around a ring of registers, all in the same clock edge. S0 is always in the ring. Each immediate bit adds one of the other five registers to the ring. The same five-bit field therefore sets both the pointer offset and which registers join the circular shift.

Software or a surrounding engine first loads all six registers in parallel. It then issues commands. It reads the register values from a flat output bus and uses the done pulse to see when a result is visible.

The controller has two states:
- `ST_IDLE` accepts commands.
- `ST_DONE` marks the cycle after a command, in which the result is shown and all inputs are ignored.

It has two transitions:
- `ST_IDLE` to `ST_DONE` is the accept transition, taken when start is sampled high.
- `ST_DONE` to `ST_IDLE` is the retire transition, always taken.

A load sampled in `ST_IDLE` without start writes the register file and stays in `ST_IDLE`.

Top module: `rotu_unit`

## Requirements
- R1: After reset, all six registers read 0, done is low and the unit is idle.
- R2: A command first replaces S0 with S0 plus the immediate sign-extended from five bits, modulo 256. The rotation then uses this new S0 value. For example, S0 = 250 with immediate 15 gives 9, and S0 = 3 with immediate -16 gives 243.
- R3: Immediate bit 4 adds S1 to the ring, bit 3 adds S2, bit 2 adds S3, bit 1 adds D0 and bit 0 adds D1. S0 is always in the ring.
- R4: The ring is ordered S0, then the selected registers from lowest immediate bit to highest, then back to S0. Each member takes the value of the member before it. Registers that are not selected keep their value. For example, from S = {0,1,2,3} and D = {4,5}, immediate -1 gives S = {1,2,3,4}, D = {5,255}; immediate -16 gives S = {1,240,2,3}, D = {4,5}; and immediate 15 gives S = {2,1,3,4}, D = {5,15}.
- R5: An immediate of 0 leaves all six registers unchanged.
- R6: The registers take the result at the clock edge that samples start. Done is high for exactly the next cycle and then falls.
- R7: Start and load sampled while done is high are ignored, and the registers hold their value.
- R8: A load sampled in the idle state without start writes all six registers from load_data in one edge.
- R9: If start and load are sampled together in the idle state, the command is executed and the load is dropped.
- R10: On both load_data and regs_o, slot i occupies bits [8i+7:8i]. Slots 0 to 3 are S0 to S3, slot 4 is D0 and slot 5 is D1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| imm | input | 5 | Signed offset and ring membership mask |
| load | input | 1 | Parallel load strobe |
| load_data | input | 48 | Six packed register values to load |
| regs_o | output | 48 | Six packed register values |
| done | output | 1 | High for one cycle after a command |

## Verification
Two pairs of functions can fall in the same cycle.

- **Start with load in the idle state.** The bench raises start and load on the same edge while idle. It judges the result by comparing the register file against the rotation model applied to the old contents, with the loaded word nowhere in it.
- **Inputs during the done cycle.** The bench also asserts start and load during the done cycle with a full-mask immediate and fresh load data. It then requires both the register file and done to show no trace of that stimulus one cycle later.

// File: rtl/rotu_pkg.sv
package rotu_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } rotu_state_e;

    // Slot in the register file visited at ring position k (k >= 1).
    function automatic int ring_slot(input int k, input int nreg);
        return nreg - k;
    endfunction

endpackage

// File: rtl/rotu_offset.sv
module rotu_offset #(
    parameter int DW    = 8,
    parameter int IMM_W = 5
) (
    input  logic [DW-1:0]    base,
    input  logic [IMM_W-1:0] imm,
    output logic [DW-1:0]    sum
);
    localparam int EXT = DW - IMM_W;

    logic [DW-1:0] imm_ext;

    assign imm_ext = {{EXT{imm[IMM_W-1]}}, imm};
    assign sum     = base + imm_ext;

endmodule

// File: rtl/rotu_permute.sv
module rotu_permute
    import rotu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 6
) (
    input  logic [NREG-1:0][DW-1:0] cur,
    input  logic [NREG-2:0]         mask,
    output logic [NREG-1:0][DW-1:0] nxt
);
    logic [DW-1:0] carry;

    // Walk the ring from slot 0 onward; each selected slot receives the
    // value carried from the previous member, then hands its own forward.
    always_comb begin
        nxt   = cur;
        carry = cur[0];
        for (int k = 1; k < NREG; k++) begin
            if (mask[k-1]) begin
                nxt[ring_slot(k, NREG)] = carry;
                carry                   = cur[ring_slot(k, NREG)];
            end
        end
        nxt[0] = carry;
    end

endmodule

// File: rtl/rotu_ctrl.sv
module rotu_ctrl
    import rotu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic load,
    output logic do_rot,
    output logic do_load,
    output logic done
);
    rotu_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        do_rot  = 1'b0;
        do_load = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                do_rot  = start;
                do_load = load && !start;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R6: done never lasts more than one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an accepted start is followed by done
    a_r6_start_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && start) |=> done);

endmodule

// File: rtl/rotu_unit.sv
module rotu_unit #(
    parameter int DW   = 8,
    parameter int NSRC = 4,
    parameter int NDST = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NSRC+NDST-2:0]         imm,
    input  logic                         load,
    input  logic [(NSRC+NDST)*DW-1:0]    load_data,
    output logic [(NSRC+NDST)*DW-1:0]    regs_o,
    output logic                         done
);
    localparam int NREG  = NSRC + NDST;
    localparam int IMM_W = NREG - 1;

    logic                       do_rot, do_load;
    logic [NREG-1:0][DW-1:0]    file_q;
    logic [NREG-1:0][DW-1:0]    ld_vals;
    logic [NREG-1:0][DW-1:0]    pre_rot;
    logic [NREG-1:0][DW-1:0]    post_rot;
    logic [DW-1:0]              s0_moved;

    rotu_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .do_rot  (do_rot),
        .do_load (do_load),
        .done    (done)
    );

    rotu_offset #(.DW(DW), .IMM_W(IMM_W)) u_offset (
        .base (file_q[0]),
        .imm  (imm),
        .sum  (s0_moved)
    );

    always_comb begin
        pre_rot    = file_q;
        pre_rot[0] = s0_moved;
    end

    rotu_permute #(.DW(DW), .NREG(NREG)) u_permute (
        .cur  (pre_rot),
        .mask (imm),
        .nxt  (post_rot)
    );

    assign ld_vals = load_data;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)       file_q[i] <= '0;
            else if (do_rot)  file_q[i] <= post_rot[i];
            else if (do_load) file_q[i] <= ld_vals[i];
        end
    end

    assign regs_o = file_q;

    // R7: register file holds across the done cycle
    a_r7_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(regs_o));

    // R5: zero immediate leaves the file unchanged
    a_r5_zero_imm: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && start && imm == '0) |=> $stable(regs_o));

    // R8: idle load without start writes the load word
    a_r8_load_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && load && !start) |=> (regs_o == $past(load_data)));

    // R9: start together with load still produces a command result
    a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && start && load) |=> done);

endmodule

// File: tb/tb_rotu_unit.sv
module tb_rotu_unit;
    localparam int DW = 8;
    localparam int NREG = 6;
    localparam int W = DW * NREG;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         load = 1'b0;
    logic [4:0]   imm = '0;
    logic [W-1:0] load_data = '0;
    wire  [W-1:0] regs;
    wire          done;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] shadow = '0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    rotu_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .imm       (imm),
        .load      (load),
        .load_data (load_data),
        .regs_o    (regs),
        .done      (done)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] pk(input int a0, a1, a2, a3, d0, d1);
        return {d1[7:0], d0[7:0], a3[7:0], a2[7:0], a1[7:0], a0[7:0]};
    endfunction

    // Reference model written from R2..R4: offset S0, list ring members, shift.
    function automatic logic [W-1:0] model(input logic [W-1:0] r, input logic [4:0] iv);
        logic [7:0] v [6];
        logic [7:0] n [6];
        int member [6];
        int cnt;
        int tgt [5] = '{5, 4, 3, 2, 1};
        logic [W-1:0] o;
        for (int i = 0; i < 6; i++) v[i] = r[i*8 +: 8];
        v[0] = v[0] + {{3{iv[4]}}, iv};
        member[0] = 0;
        cnt = 1;
        for (int b = 0; b < 5; b++) if (iv[b]) begin member[cnt] = tgt[b]; cnt++; end
        for (int i = 0; i < 6; i++) n[i] = v[i];
        for (int j = 1; j < cnt; j++) n[member[j]] = v[member[j-1]];
        n[0] = v[member[cnt-1]];
        for (int i = 0; i < 6; i++) o[i*8 +: 8] = n[i];
        return o;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every done cycle pops one expected result.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6: actual done=1 expected no result pending");
            end else begin
                check(tag_q.pop_front(), regs, exp_q.pop_front());
            end
        end
    end

    task automatic do_load(input logic [W-1:0] v, input string tag);
        @(negedge clk);
        load = 1'b1;
        load_data = v;
        @(negedge clk);
        load = 1'b0;
        check(tag, regs, v);
        check("R8 done low", W'(done), '0);
        shadow = v;
    endtask

    task automatic do_op(input logic [4:0] iv, input string tag, input bit poke);
        @(negedge clk);
        start = 1'b1;
        imm = iv;
        shadow = model(shadow, iv);
        exp_q.push_back(shadow);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1;
            load = 1'b1;
            imm = 5'h1f;
            load_data = {W{1'b1}};
            @(negedge clk);
            start = 1'b0;
            load = 1'b0;
            check("R7 regs after busy stimulus", regs, shadow);
            check("R7 done low", W'(done), '0);
        end else begin
            @(negedge clk);
            check("R6 done one cycle", W'(done), '0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 regs reset", regs, '0);
        check("R1 done reset", W'(done), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", regs, '0);

        do_load(pk(0, 1, 2, 3, 4, 5), "R8 R10 load");
        do_op(5'h1f, "R4 imm -1", 1'b0);
        check("R4 example -1", regs, pk(1, 2, 3, 4, 5, 255));

        do_load(pk(0, 1, 2, 3, 4, 5), "R8 reload");
        do_op(5'h10, "R3 imm -16", 1'b0);
        check("R3 example -16", regs, pk(1, 240, 2, 3, 4, 5));

        do_load(pk(0, 1, 2, 3, 4, 5), "R8 reload");
        do_op(5'h0f, "R4 imm 15", 1'b1);
        check("R4 example 15", regs, pk(2, 1, 3, 4, 5, 15));

        do_load(pk(9, 8, 7, 6, 5, 4), "R10 load");
        do_op(5'h00, "R5 imm 0", 1'b0);
        check("R5 unchanged", regs, pk(9, 8, 7, 6, 5, 4));

        do_load(pk(250, 11, 22, 33, 44, 55), "R8 load");
        do_op(5'h0f, "R2 wrap up", 1'b0);
        do_load(pk(3, 11, 22, 33, 44, 55), "R8 load");
        do_op(5'h10, "R2 wrap down", 1'b0);
        check("R2 sR0 wrap down", regs, pk(11, 243, 22, 33, 44, 55));
        do_op(5'h01, "R3 bit0 D1", 1'b0);
        do_op(5'h02, "R3 bit1 D0", 1'b1);
        do_op(5'h0a, "R4 mask 01010", 1'b0);
        do_op(5'h15, "R4 mask 10101", 1'b0);

        // R9: start and load in the same idle cycle
        @(negedge clk);
        start = 1'b1;
        load = 1'b1;
        imm = 5'h13;
        load_data = pk(77, 77, 77, 77, 77, 77);
        shadow = model(shadow, 5'h13);
        exp_q.push_back(shadow);
        tag_q.push_back("R9 collision");
        @(negedge clk);
        start = 1'b0;
        load = 1'b0;
        @(negedge clk);
        check("R9 load dropped", regs, shadow);

        // back-to-back commands without idle gap in stimulus
        do_op(5'h1c, "R6 back to back", 1'b0);
        do_op(5'h07, "R6 back to back", 1'b0);

        repeat (2) @(negedge clk);
        check("R6 all results seen", W'(exp_q.size()), '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule